// File: doc/BRIEF.md
# Three-Channel Prescaled Interval Timer

This block provides three programmable interval timers for an audio coprocessor. A single-cycle fast tick input drives them: the fast channel (channel 2) steps on every fast tick. Channels 0 and 1 step once every eight fast ticks, through a shared divide-by-8 prescaler. Each channel counts its steps up to an 8-bit period. When the count reaches the period, the count returns to zero and the channel's 4-bit event counter goes up by one.

Software programs the block through a byte-wide write port. One address holds a control byte and three addresses hold the channel periods. The control byte also gives two one-cycle strobes that clear pairs of host-to-coprocessor ports, and a flag that maps a 64-byte boot ROM into the top of the address space. A read port returns the event counter of one channel. The read also clears that counter, so every event is reported exactly once.

Top module: `tri_interval_timer`

## Requirements
- R1: Channel 2 steps on every cycle with `tick_i` high. Channels 0 and 1 step only on the 8th, 16th, 24th, ... tick counted from reset.
- R2: A period value of 0 means a period of 256 steps.
- R3: When a step brings a channel's stage count up to its period, the stage count returns to 0 and the 4-bit event counter increments modulo 16.
- R4: Writing the control byte (`wr_sel_i`=0) sets the enables: bit 0 for channel 0, bit 1 for channel 1, bit 2 for channel 2. An enable that goes from 0 to 1 zeroes that channel's stage count and event counter. Rewriting a 1 over a 1 leaves the channel running undisturbed.
- R5: A control write with bit 4 set gives a one-cycle pulse on `port_clr_lo_o` in the cycle after the write. Bit 5 does the same on `port_clr_hi_o`.
- R6: `rom_visible_o` takes the value of control bit 7 on each control write and is 1 after reset.
- R7: A period write (`wr_sel_i`=1, 2 or 3 for channel 0, 1 or 2) applies to the very next step comparison, even while the channel runs.
- R8: A read (`rd_en_i`, `rd_sel_i`=0..2) shows the channel's event counter on `rd_data_o` in the same cycle and clears the counter at the clock edge. An increment in that same cycle is lost. `rd_sel_i`=3 reads 0.
- R9: A disabled channel holds its stage count and event counter.
- R10: The prescaler counts fast ticks whatever the enables are, and only a block reset returns it to 0.
- R11: After reset all channels are disabled, all periods are 0, all event counters read 0 and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | Fast tick, one step per high cycle |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 control, 1..3 period of channel 0..2 |
| wr_data_i | input | 8 | Write data |
| rd_en_i | input | 1 | Read-and-clear strobe |
| rd_sel_i | input | 2 | Channel to read, 0..2 |
| rd_data_o | output | 4 | Event counter of the selected channel |
| port_clr_lo_o | output | 1 | One-cycle strobe that clears ports 0 and 1 |
| port_clr_hi_o | output | 1 | One-cycle strobe that clears ports 2 and 3 |
| rom_visible_o | output | 1 | Boot ROM mapped into the address space |

## Verification
The bench changes a running channel's period. A design that latched the period only at enable time would miss the expected event. It re-enables a channel after a pause. A design that failed to clear on the rising enable would report an early event, and one that restarted on every control write would lose an event. It reads a counter on the same cycle as an increment: a design that let the increment win would then read 1 instead of 0. The bench also counts ticks from reset to predict exactly when channels 0 and 1 step, so a prescaler gated by the enables, or reset by them, would shift every slow-channel result.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned TMR_N      = 3;
  localparam int unsigned TMR_TGT_W  = 8;
  localparam int unsigned TMR_OUT_W  = 4;
  localparam int unsigned TMR_PRE_W  = 3;
  localparam int unsigned TMR_FAST   = 2;
  localparam int unsigned CTL_CLR_LO = 4;
  localparam int unsigned CTL_CLR_HI = 5;
  localparam int unsigned CTL_ROM    = 7;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_PER0 = 2'd1,
    SEL_PER1 = 2'd2,
    SEL_PER2 = 2'd3
  } wr_sel_e;
endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned PRE_W = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  output logic step_o
);
  logic [PRE_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (tick_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign step_o = tick_i && (cnt_q == {PRE_W{1'b1}});

  // R1: a slow step is never followed directly by another slow step
  p_slow_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
    step_o |=> !step_o);
  // R10: the prescaler advances on every tick whatever else happens
  p_free_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> cnt_q == PRE_W'($past(cnt_q) + 1'b1));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int unsigned TGT_W = 8,
  parameter int unsigned OUT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             start_i,
  input  logic             step_i,
  input  logic             rd_clr_i,
  input  logic [TGT_W-1:0] period_i,
  output logic [OUT_W-1:0] out_o
);
  localparam int unsigned PER_W = TGT_W + 1;

  logic [TGT_W-1:0] stage_q, stage_d;
  logic [OUT_W-1:0] out_q, out_d;
  logic [PER_W-1:0] period_full, stage_inc;
  logic             wrap;

  assign period_full = (period_i == '0) ? (PER_W'(1) << TGT_W) : {1'b0, period_i};
  assign stage_inc   = {1'b0, stage_q} + 1'b1;
  assign wrap        = (stage_inc >= period_full);

  always_comb begin
    stage_d = stage_q;
    out_d   = out_q;
    if (start_i) begin
      stage_d = '0;
      out_d   = '0;
    end else begin
      if (en_i && step_i) begin
        if (wrap) begin
          stage_d = '0;
          out_d   = out_q + 1'b1;
        end else begin
          stage_d = stage_inc[TGT_W-1:0];
        end
      end
      if (rd_clr_i) out_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      out_q   <= '0;
    end else begin
      stage_q <= stage_d;
      out_q   <= out_d;
    end
  end

  assign out_o = out_q;

  // R4: a rising enable leaves a zeroed channel
  p_start_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (out_q == '0) && (stage_q == '0));
  // R8: a read always leaves the counter at zero
  p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr_i |=> out_q == '0);
  // R9: an idle disabled channel keeps its state
  p_hold_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !start_i && !rd_clr_i) |=> $stable(out_q) && $stable(stage_q));
  // R3: without start or read the counter moves by at most one
  p_step_by_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !rd_clr_i) |=> (out_q == $past(out_q)) || (out_q == OUT_W'($past(out_q) + 1'b1)));
endmodule

// File: rtl/tri_interval_timer.sv
module tri_interval_timer
  import tmr_pkg::*;
#(
  parameter int unsigned N     = TMR_N,
  parameter int unsigned TGT_W = TMR_TGT_W,
  parameter int unsigned OUT_W = TMR_OUT_W,
  parameter int unsigned PRE_W = TMR_PRE_W,
  parameter int unsigned FAST  = TMR_FAST
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [7:0]       wr_data_i,
  input  logic             rd_en_i,
  input  logic [1:0]       rd_sel_i,
  output logic [OUT_W-1:0] rd_data_o,
  output logic             port_clr_lo_o,
  output logic             port_clr_hi_o,
  output logic             rom_visible_o
);
  logic             rst_n_s;
  logic             slow_step;
  logic             ctrl_wr;
  logic [N-1:0]     en_q, en_d, start, step, rd_clr;
  logic [TGT_W-1:0] per_q [N];
  logic [TGT_W-1:0] per_d [N];
  logic [OUT_W-1:0] cnt   [N];
  logic             rom_q, rom_d, clr_lo_q, clr_lo_d, clr_hi_q, clr_hi_d;

  tmr_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n_s), .tick_i(tick_i), .step_o(slow_step));

  assign ctrl_wr = wr_en_i && (wr_sel_i == SEL_CTRL);

  always_comb begin
    en_d     = ctrl_wr ? wr_data_i[N-1:0] : en_q;
    start    = ctrl_wr ? (wr_data_i[N-1:0] & ~en_q) : '0;
    rom_d    = ctrl_wr ? wr_data_i[CTL_ROM] : rom_q;
    clr_lo_d = ctrl_wr && wr_data_i[CTL_CLR_LO];
    clr_hi_d = ctrl_wr && wr_data_i[CTL_CLR_HI];
    for (int i = 0; i < N; i++) begin
      per_d[i]  = (wr_en_i && (wr_sel_i == 2'(i + 1))) ? wr_data_i[TGT_W-1:0] : per_q[i];
      rd_clr[i] = rd_en_i && (rd_sel_i == 2'(i));
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      en_q     <= '0;
      rom_q    <= 1'b1;
      clr_lo_q <= 1'b0;
      clr_hi_q <= 1'b0;
      for (int i = 0; i < N; i++) per_q[i] <= '0;
    end else begin
      en_q     <= en_d;
      rom_q    <= rom_d;
      clr_lo_q <= clr_lo_d;
      clr_hi_q <= clr_hi_d;
      for (int i = 0; i < N; i++) per_q[i] <= per_d[i];
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_ch
    if (g == FAST) begin : g_fast
      assign step[g] = tick_i;
    end else begin : g_slow
      assign step[g] = slow_step;
    end
    tmr_channel #(.TGT_W(TGT_W), .OUT_W(OUT_W)) u_ch (
      .clk(clk), .rst_n(rst_n_s), .en_i(en_q[g]), .start_i(start[g]),
      .step_i(step[g]), .rd_clr_i(rd_clr[g]), .period_i(per_q[g]), .out_o(cnt[g]));
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < N; i++)
      if (rd_sel_i == 2'(i)) rd_data_o = cnt[i];
  end

  assign port_clr_lo_o = clr_lo_q;
  assign port_clr_hi_o = clr_hi_q;
  assign rom_visible_o = rom_q;

  // R6: the ROM flag follows bit 7 of the last control write
  p_rom_follows_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    ctrl_wr |=> rom_visible_o == $past(wr_data_i[CTL_ROM]));
  // R5: without a new control write the strobes drop after one cycle
  p_strobe_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (port_clr_lo_o && !ctrl_wr) |=> !port_clr_lo_o);
  // R4: a control write without a set enable bit stops the channel
  p_enable_low_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (ctrl_wr && !wr_data_i[FAST]) |=> !en_q[FAST]);
endmodule

// File: tb/tri_interval_timer_tb_top.sv
module tri_interval_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0, wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [1:0] wr_sel_i = '0, rd_sel_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [3:0] rd_data_o;
  logic       port_clr_lo_o, port_clr_hi_o, rom_visible_o;

  int n_chk = 0, n_bad = 0, cyc = 0, tick_total = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tri_interval_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .rd_en_i(rd_en_i),
    .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o), .port_clr_lo_o(port_clr_lo_o),
    .port_clr_hi_o(port_clr_hi_o), .rom_visible_o(rom_visible_o));

  // vector: op[17:16] (0 write, 1 ticks, 2 read), sel[15:14], arg[13:4], expected[3:0]
  localparam int NV = 35;
  localparam logic [17:0] VEC [NV] = '{
    {2'd0, 2'd3, 10'd3,    4'd0}, // period2 = 3
    {2'd0, 2'd0, 10'h084,  4'd0}, // enable ch2
    {2'd1, 2'd0, 10'd9,    4'd0},
    {2'd2, 2'd2, 10'd0,    4'd3}, // R1 R3
    {2'd1, 2'd0, 10'd2,    4'd0},
    {2'd2, 2'd2, 10'd0,    4'd0}, // R8 cleared
    {2'd1, 2'd0, 10'd1,    4'd0},
    {2'd2, 2'd2, 10'd0,    4'd1},
    {2'd0, 2'd3, 10'd0,    4'd0}, // period 0 -> 256
    {2'd1, 2'd0, 10'd255,  4'd0},
    {2'd2, 2'd2, 10'd0,    4'd0}, // R2
    {2'd1, 2'd0, 10'd1,    4'd0},
    {2'd2, 2'd2, 10'd0,    4'd1}, // R2
    {2'd0, 2'd3, 10'd5,    4'd0},
    {2'd1, 2'd0, 10'd2,    4'd0},
    {2'd0, 2'd3, 10'd3,    4'd0}, // live change
    {2'd1, 2'd0, 10'd1,    4'd0},
    {2'd2, 2'd2, 10'd0,    4'd1}, // R7
    {2'd1, 2'd0, 10'd4,    4'd0},
    {2'd0, 2'd0, 10'h080,  4'd0}, // disable
    {2'd1, 2'd0, 10'd30,   4'd0},
    {2'd2, 2'd2, 10'd0,    4'd1}, // R9
    {2'd0, 2'd0, 10'h084,  4'd0}, // re-enable
    {2'd1, 2'd0, 10'd2,    4'd0},
    {2'd2, 2'd2, 10'd0,    4'd0}, // R4 stage cleared
    {2'd0, 2'd0, 10'h084,  4'd0}, // rewrite 1 over 1
    {2'd1, 2'd0, 10'd1,    4'd0},
    {2'd2, 2'd2, 10'd0,    4'd1}, // R4 no restart
    {2'd1, 2'd0, 10'd3,    4'd0},
    {2'd0, 2'd0, 10'h080,  4'd0},
    {2'd0, 2'd0, 10'h084,  4'd0},
    {2'd2, 2'd2, 10'd0,    4'd0}, // R4 counter cleared
    {2'd0, 2'd3, 10'd1,    4'd0},
    {2'd1, 2'd0, 10'd17,   4'd0},
    {2'd2, 2'd2, 10'd0,    4'd1}  // R3 modulo 16
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int sel, input int data);
    @(negedge clk);
    wr_en_i = 1'b1; wr_sel_i = 2'(sel); wr_data_i = 8'(data);
    @(posedge clk);
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      @(negedge clk);
      tick_i = 1'b1;
      repeat (n) begin
        @(posedge clk);
        tick_total++;
      end
      @(negedge clk);
      tick_i = 1'b0;
    end
  endtask

  task automatic rd(input int sel, input bit tk, output int val);
    @(negedge clk);
    rd_en_i = 1'b1; rd_sel_i = 2'(sel); tick_i = tk;
    #1 val = int'(rd_data_o);
    @(posedge clk);
    if (tk) tick_total++;
    @(negedge clk);
    rd_en_i = 1'b0; tick_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state, R6 ROM flag set
    check("R6 rom after reset", int'(rom_visible_o), 1);
    check("R11 clr_lo after reset", int'(port_clr_lo_o), 0);
    check("R11 clr_hi after reset", int'(port_clr_hi_o), 0);
    for (int c = 0; c < 3; c++) begin
      rd(c, 1'b0, v);
      check("R11 counter after reset", v, 0);
    end

    // R5 / R6 control side effects
    wr(0, 8'h10);
    check("R5 clr_lo pulse", int'(port_clr_lo_o), 1);
    check("R5 clr_hi quiet", int'(port_clr_hi_o), 0);
    check("R6 rom cleared", int'(rom_visible_o), 0);
    @(negedge clk);
    check("R5 clr_lo one cycle", int'(port_clr_lo_o), 0);
    wr(0, 8'h20);
    check("R5 clr_hi pulse", int'(port_clr_hi_o), 1);
    check("R5 clr_lo quiet", int'(port_clr_lo_o), 0);
    wr(0, 8'hB0);
    check("R5 both strobes", int'(port_clr_lo_o & port_clr_hi_o), 1);
    check("R6 rom set", int'(rom_visible_o), 1);
    @(negedge clk);

    // vector table on the fast channel
    for (int i = 0; i < NV; i++) begin
      case (VEC[i][17:16])
        2'd0: wr(int'(VEC[i][15:14]), int'(VEC[i][11:4]));
        2'd1: ticks(int'(VEC[i][13:4]));
        default: begin
          rd(int'(VEC[i][15:14]), 1'b0, v);
          check($sformatf("R1/R2/R3/R4/R7/R8/R9 vector %0d", i), v, int'(VEC[i][3:0]));
        end
      endcase
    end

    // R8: read collides with an increment (period 1 on channel 2)
    ticks(3);
    rd(2, 1'b1, v);
    check("R8 read value on collision", v, 3);
    rd(2, 1'b0, v);
    check("R8 increment lost to clear", v, 0);
    rd(3, 1'b0, v);
    check("R8 unused select reads 0", v, 0);

    // R1 / R10: slow channels, phase predicted from ticks since reset
    while (tick_total % 8 != 0) ticks(1);
    wr(1, 2);
    wr(0, 8'h85);
    ticks(15);
    rd(0, 1'b0, v);
    check("R1 slow channel before 16 ticks", v, 0);
    ticks(1);
    rd(0, 1'b0, v);
    check("R10 slow channel at prescaler phase", v, 1);
    wr(2, 3);
    wr(0, 8'h87);
    ticks(24);
    rd(1, 1'b0, v);
    check("R1 channel 1 after 24 ticks", v, 1);
    rd(0, 1'b0, v);
    check("R4 channel 0 not restarted", v, 1);

    finish_run();
  end
endmodule